// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Decision

This block holds the exception part of a floating-point status word. When an arithmetic unit finishes an operation it reports five raw IEEE 754 flags with a valid strobe. The block gathers these flags into a pending set that persists until a clear. On each valid operation it merges the pending set into the current-exception field and compares the result with the trap-enable field of the same word.

If any flagged exception is also enabled, the block writes the IEEE-exception code into the trap-type field and raises a one-cycle trap pulse. In that case the accrued field is left alone. If no enabled exception is present, the current exceptions are ORed into the accrued field instead. An operation that brings no flags at all leaves the word untouched.

Software may overwrite the whole word through a write port. In a cycle that has both a write and an operation, the write wins. A clear input empties the pending raw-flag set before the next operation.

Top module: `fp_exc_status`

## Requirements
- R1: After reset `stat_q` is 0, `trap_pulse` is 0 and the pending raw-flag set is empty.
- R2: Flags are ordered invalid, overflow, underflow, divide-by-zero, inexact at bits 4,3,2,1,0 of `flag_in`. The current-exception field `stat_q[4:0]` uses the same order. A valid operation that is not overridden by a software write sets that field to its old value ORed with the effective raw flags (the pending set plus `flag_in`).
- R3: If the new current field ANDed with the trap-enable field `stat_q[27:23]` is non-zero, `stat_q[16:14]` becomes 3'b001. `trap_pulse` is 1 in the cycle the word shows the update. The accrued field `stat_q[9:5]` is unchanged.
- R4: If that AND is zero, the accrued field `stat_q[9:5]` is ORed with the new current field. The trap-type field is unchanged and `trap_pulse` stays 0.
- R5: A valid operation whose effective raw flags are all zero, or any cycle without an operation or a write, leaves `stat_q` unchanged and `trap_pulse` at 0.
- R6: Raw flags from every valid operation stay pending and take part in later operations until `flag_clr`. A clear in the same cycle as an operation discards the old pending set but keeps that operation's flags.
- R7: When `sw_wr` is 1, `stat_q` takes `sw_wdata` on the next edge and `trap_pulse` stays 0, even if `flag_vld` is also 1.
- R8: `trap_pulse` lasts one cycle unless the next cycle also holds a trapping operation.
- R9: Bits of `stat_q` outside the current, accrued and trap-type fields change only through software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_vld | input | 1 | An operation completed this cycle |
| flag_in | input | 5 | Raw flags of that operation (NV,OF,UF,DZ,NX high to low) |
| flag_clr | input | 1 | Empty the pending raw-flag set |
| sw_wr | input | 1 | Software write strobe for the status word |
| sw_wdata | input | 32 | Value written by software |
| stat_q | output | 32 | Status word contents |
| trap_pulse | output | 1 | Floating-point exception trap request |

## Verification
Two pairs of functions can fall in the same cycle: a software write and a completed operation, and a clear and a completed operation. The bench provokes the first pair by raising `sw_wr` and `flag_vld` together with enabled flags. It then expects the written value exactly and no trap pulse. It provokes the second pair after leaving a different flag pending, and it expects that only the new operation's flag reaches the current and accrued fields. A sweep over every enable mask and every non-zero flag vector checks the trap-or-accrue choice against a model computed in the bench.

// File: rtl/fp_exc_pkg.sv
package fp_exc_pkg;

    // Default field geometry of the status word.
    localparam int unsigned FLAG_N_DEF  = 5;
    localparam int unsigned STAT_W_DEF  = 32;
    localparam int unsigned CUR_LSB_DEF = 0;
    localparam int unsigned ACC_LSB_DEF = 5;
    localparam int unsigned TEM_LSB_DEF = 23;
    localparam int unsigned TT_LSB_DEF  = 14;
    localparam int unsigned TT_W_DEF    = 3;
    localparam int unsigned TT_IEEE_DEF = 1;

    // Flag positions inside a flag vector.
    localparam int unsigned FLG_NX = 0;
    localparam int unsigned FLG_DZ = 1;
    localparam int unsigned FLG_UF = 2;
    localparam int unsigned FLG_OF = 3;
    localparam int unsigned FLG_NV = 4;

endpackage

// File: rtl/fp_exc_pending.sv
module fp_exc_pending #(
    parameter int unsigned FLAG_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_vld,
    input  logic [FLAG_N-1:0] flag_in,
    input  logic              flag_clr,
    output logic [FLAG_N-1:0] eff_flags
);

    typedef struct packed {
        logic [FLAG_N-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flag_clr) begin
            st_d.pend = '0;
        end
        if (flag_vld) begin
            st_d.pend = st_d.pend | flag_in;
        end
    end

    assign eff_flags = st_d.pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !flag_vld) |=> (st_q.pend == '0));

    // R6
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr) |=> ((st_q.pend & $past(st_q.pend)) == $past(st_q.pend)));

endmodule

// File: rtl/fp_exc_eval.sv
module fp_exc_eval #(
    parameter int unsigned STAT_W  = 32,
    parameter int unsigned FLAG_N  = 5,
    parameter int unsigned CUR_LSB = 0,
    parameter int unsigned ACC_LSB = 5,
    parameter int unsigned TEM_LSB = 23,
    parameter int unsigned TT_LSB  = 14,
    parameter int unsigned TT_W    = 3,
    parameter int unsigned TT_IEEE = 1
) (
    input  logic [STAT_W-1:0] stat_i,
    input  logic [FLAG_N-1:0] raw_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              trap_o,
    output logic              any_o
);

    localparam logic [TT_W-1:0] TT_CODE = TT_W'(TT_IEEE);

    logic [FLAG_N-1:0] cur_old;
    logic [FLAG_N-1:0] cur_new;
    logic [FLAG_N-1:0] enab;
    logic [FLAG_N-1:0] hit;

    assign cur_old = stat_i[CUR_LSB +: FLAG_N];
    assign enab    = stat_i[TEM_LSB +: FLAG_N];
    assign cur_new = cur_old | raw_i;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_hit
        assign hit[i] = cur_new[i] & enab[i];
    end

    assign trap_o = |hit;
    assign any_o  = |raw_i;

    always_comb begin
        stat_o = stat_i;
        stat_o[CUR_LSB +: FLAG_N] = cur_new;
        if (trap_o) begin
            stat_o[TT_LSB +: TT_W] = TT_CODE;
        end else begin
            stat_o[ACC_LSB +: FLAG_N] = stat_i[ACC_LSB +: FLAG_N] | cur_new;
        end
    end

endmodule

// File: rtl/fp_exc_status.sv
module fp_exc_status #(
    parameter int unsigned STAT_W  = fp_exc_pkg::STAT_W_DEF,
    parameter int unsigned FLAG_N  = fp_exc_pkg::FLAG_N_DEF,
    parameter int unsigned CUR_LSB = fp_exc_pkg::CUR_LSB_DEF,
    parameter int unsigned ACC_LSB = fp_exc_pkg::ACC_LSB_DEF,
    parameter int unsigned TEM_LSB = fp_exc_pkg::TEM_LSB_DEF,
    parameter int unsigned TT_LSB  = fp_exc_pkg::TT_LSB_DEF,
    parameter int unsigned TT_W    = fp_exc_pkg::TT_W_DEF,
    parameter int unsigned TT_IEEE = fp_exc_pkg::TT_IEEE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_vld,
    input  logic [FLAG_N-1:0] flag_in,
    input  logic              flag_clr,
    input  logic              sw_wr,
    input  logic [STAT_W-1:0] sw_wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic              trap_pulse
);

    localparam logic [TT_W-1:0] TT_CODE = TT_W'(TT_IEEE);

    // Bits owned by the exception fields; the rest belong to software.
    localparam logic [STAT_W-1:0] OWN_MASK =
        ({{(STAT_W-FLAG_N){1'b0}}, {FLAG_N{1'b1}}} << CUR_LSB) |
        ({{(STAT_W-FLAG_N){1'b0}}, {FLAG_N{1'b1}}} << ACC_LSB) |
        ({{(STAT_W-TT_W){1'b0}}, {TT_W{1'b1}}} << TT_LSB);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              trap;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [FLAG_N-1:0] eff_flags;
    logic [STAT_W-1:0] eval_stat;
    logic              eval_trap;
    logic              eval_any;

    fp_exc_pending #(
        .FLAG_N (FLAG_N)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_vld  (flag_vld),
        .flag_in   (flag_in),
        .flag_clr  (flag_clr),
        .eff_flags (eff_flags)
    );

    fp_exc_eval #(
        .STAT_W  (STAT_W),
        .FLAG_N  (FLAG_N),
        .CUR_LSB (CUR_LSB),
        .ACC_LSB (ACC_LSB),
        .TEM_LSB (TEM_LSB),
        .TT_LSB  (TT_LSB),
        .TT_W    (TT_W),
        .TT_IEEE (TT_IEEE)
    ) u_eval (
        .stat_i (st_q.stat),
        .raw_i  (eff_flags),
        .stat_o (eval_stat),
        .trap_o (eval_trap),
        .any_o  (eval_any)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (sw_wr) begin
            st_d.stat = sw_wdata;
        end else if (flag_vld && eval_any) begin
            st_d.stat = eval_stat;
            st_d.trap = eval_trap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q     = st_q.stat;
    assign trap_pulse = st_q.trap;

    // R3
    trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (stat_q[TT_LSB +: TT_W] == TT_CODE));

    // R3
    trap_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (stat_q[ACC_LSB +: FLAG_N] == $past(stat_q[ACC_LSB +: FLAG_N])));

    // R7
    sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> ((stat_q == $past(sw_wdata)) && !trap_pulse));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && !flag_vld) |=> ($stable(stat_q) && !trap_pulse));

    // R8
    trap_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> ($past(flag_vld) && !$past(sw_wr)));

    // R2
    cur_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr) |=> ((stat_q[CUR_LSB +: FLAG_N] & $past(stat_q[CUR_LSB +: FLAG_N]))
                      == $past(stat_q[CUR_LSB +: FLAG_N])));

    // R9
    other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr) |=> ((stat_q & ~OWN_MASK) == ($past(stat_q) & ~OWN_MASK)));

endmodule

// File: tb/fp_exc_status_bench.sv
module fp_exc_status_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flag_vld;
    logic [4:0]  flag_in;
    logic        flag_clr;
    logic        sw_wr;
    logic [31:0] sw_wdata;
    logic [31:0] stat_q;
    logic        trap_pulse;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fp_exc_status u_fp_exc_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_vld   (flag_vld),
        .flag_in    (flag_in),
        .flag_clr   (flag_clr),
        .sw_wr      (sw_wr),
        .sw_wdata   (sw_wdata),
        .stat_q     (stat_q),
        .trap_pulse (trap_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        flag_vld = 1'b0; flag_in = '0; flag_clr = 1'b0; sw_wr = 1'b0; sw_wdata = '0;
    endtask

    // Model: cur[4:0], acc[9:5], type[16:14], enable[27:23].
    function automatic logic [32:0] model(input logic [31:0] s, input logic [4:0] eff);
        logic [31:0] r;
        logic [4:0]  cur;
        logic        tr;
        r   = s;
        cur = s[4:0] | eff;
        tr  = (cur & s[27:23]) != 5'd0;
        r[4:0] = cur;
        if (tr) r[16:14] = 3'b001;
        else    r[9:5]   = s[9:5] | cur;
        if (eff == 5'd0) begin
            r  = s;
            tr = 1'b0;
        end
        return {tr, r};
    endfunction

    task automatic write_clr(input logic [31:0] v);
        idle();
        sw_wr = 1'b1; sw_wdata = v; flag_clr = 1'b1;
        step();
        idle();
    endtask

    task automatic op(input logic clr, input logic [4:0] f);
        idle();
        flag_vld = 1'b1; flag_in = f; flag_clr = clr;
        step();
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [32:0] e;
        logic [31:0] init;
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 stat", stat_q, 32'h0);
        chk("R1 trap", {31'd0, trap_pulse}, 32'h0);
        rst_n = 1'b1;
        // R1 pending empty: an operation with no flags changes nothing
        op(1'b0, 5'd0);
        chk("R1 R5 empty op stat", stat_q, 32'h0);
        chk("R1 R5 empty op trap", {31'd0, trap_pulse}, 32'h0);

        // R2 R3 R4 R9 sweep over every enable mask and non-zero flag vector
        for (int m = 0; m < 32; m++) begin
            for (int f = 1; f < 32; f++) begin
                init = 32'h4000_0C00 | (32'(m) << 23) | 32'((f * 3) & 31)
                     | (32'((m * 5) & 31) << 5) | ((m % 2 == 1) ? (32'h6 << 14) : 32'h0);
                write_clr(init);
                op(1'b0, 5'(f));
                e = model(init, 5'(f));
                chk("R2 R3 R4 R9 stat", stat_q, e[31:0]);
                chk("R3 R4 trap", {31'd0, trap_pulse}, {31'd0, e[32]});
                if ((f % 8) == 0) begin
                    step();
                    chk("R8 trap falls", {31'd0, trap_pulse}, 32'h0);
                end
            end
        end

        // R6 pending flags reach a later empty-flag operation
        write_clr(32'h0F80_0000);
        op(1'b0, 5'b00001);
        chk("R3 first trap", {31'd0, trap_pulse}, 32'h1);
        op(1'b0, 5'b00000);
        chk("R6 pending retrap", {31'd0, trap_pulse}, 32'h1);
        chk("R6 pending stat", stat_q, 32'h0F80_4001);
        // R6 clear then empty op: no change
        idle(); flag_clr = 1'b1; step(); idle();
        op(1'b0, 5'b00000);
        chk("R5 R6 cleared no trap", {31'd0, trap_pulse}, 32'h0);
        chk("R5 R6 cleared stat", stat_q, 32'h0F80_4001);

        // R6 clear together with an operation keeps only the new flags
        write_clr(32'h0);
        op(1'b0, 5'b01000);
        chk("R4 overflow accrued", stat_q, 32'h0000_0108);
        write_clr(32'h0);
        op(1'b0, 5'b10000);
        write_clr_keep: begin
            idle(); sw_wr = 1'b1; sw_wdata = 32'h0; step(); idle();
        end
        op(1'b1, 5'b00001);
        chk("R6 clear with op", stat_q, 32'h0000_0021);

        // R7 write and trapping operation in the same cycle
        write_clr(32'h0F80_0000);
        idle();
        sw_wr = 1'b1; sw_wdata = 32'h1234_0000; flag_vld = 1'b1; flag_in = 5'b11111;
        step();
        idle();
        chk("R7 write wins stat", stat_q, 32'h1234_0000);
        chk("R7 write wins trap", {31'd0, trap_pulse}, 32'h0);

        // R5 quiet cycles hold the word
        step();
        chk("R5 hold stat", stat_q, 32'h1234_0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule